// File: doc/BRIEF.md
# Seven-Source Two-Level Interrupt Controller

This block decides which interrupt an 8051-class core should take next. Seven sources feed it: external inputs 0 to 3, two timer overflow strobes and a serial-port flag. Each source is gated by its own enable bit and placed at one of two levels by a priority bit. A global enable gates everything. The two added external inputs are controlled through an 8-bit, bit-addressable control register that the block holds itself. The enable, priority and trigger bits of the five standard sources arrive as plain inputs from the core's own registers.

The block samples the active-low external pins once per clock. Depending on the trigger bit, it either latches a falling edge or follows the low level. It then combines the pending flags with the enables and priorities and offers one request, with its vector address, to the core. When the core accepts the request, the block marks that level as in service and clears the flag in hardware wherever that applies. A return pulse from the core closes the innermost active level. The request doubles as the wake-up signal that ends idle mode.

Top module: `irq_ctl7`

## Requirements
- R1: The vector address on `irq_vec` is 8'h03 for external 0, 8'h0B for timer 0, 8'h13 for external 1, 8'h1B for timer 1, 8'h23 for serial, 8'h33 for external 2 and 8'h3B for external 3.
- R2: Among eligible sources of one level, the winner follows the fixed order external 0, timer 0, external 1, timer 1, serial, external 2, external 3, with the first in that order winning.
- R3: The control register reads, from bit 7 to bit 0, as: priority 3, enable 3, flag 3, trigger 3, priority 2, enable 2, flag 2, trigger 2. It resets to 8'h00. A byte write with `xw_byte` loads the whole register, including both flags when the inputs are in edge mode.
- R4: With its trigger bit at 1, an external input sets its flag when one sample is high and the next is low. The flag is visible two clock edges after the pin falls. A pin held low does not set the flag again.
- R5: Accepting a request (`ack` while `irq_req` is high) clears the flag of the winning source if that source is an edge-mode external input or a timer. If an edge arrives on the same clock, the new edge wins.
- R6: With its trigger bit at 0, an external input's flag equals the inverse of the pin as sampled on the last clock edge, and it is not latched.
- R7: A high-level request is offered in preference to any low-level request. It is still offered while a low-level routine is in service. No request is offered while a high-level routine is in service, and no low-level request is offered while a low-level routine is in service.
- R8: A `reti` pulse clears the high in-service flag if that flag is set, and otherwise clears the low one.
- R9: With `gie` low no request is offered. A source whose enable bit is 0 is never offered.
- R10: `wake` is high exactly when a request is offered.
- R11: A bit write with `xw_bit` (and `xw_byte` low) changes only the bit selected by `xw_idx`. A bit write aimed at a flag position loads that flag.
- R12: `tmr0_evt` and `tmr1_evt` set the timer flags, which stay set until accepted. `ser_flag` is taken as a level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_n | input | 4 | External interrupt pins 3..0, active low |
| std_it | input | 2 | Trigger type for external 1..0 (1 = edge) |
| std_en | input | 5 | Enables of serial, timer 1, external 1, timer 0, external 0 (bits 4..0) |
| std_pri | input | 5 | Priority bits in the same order as std_en |
| gie | input | 1 | Global enable |
| tmr0_evt | input | 1 | Timer 0 overflow strobe |
| tmr1_evt | input | 1 | Timer 1 overflow strobe |
| ser_flag | input | 1 | Serial port flag, level |
| xw_byte | input | 1 | Byte write strobe for the control register |
| xw_data | input | 8 | Byte write data |
| xw_bit | input | 1 | Bit write strobe |
| xw_idx | input | 3 | Bit position for a bit write |
| xw_val | input | 1 | Bit write value |
| xctl_rd | output | 8 | Control register read value |
| ack | input | 1 | Core accepts the offered request |
| reti | input | 1 | Core returns from an interrupt routine |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | 8 | Vector address of the offered request |
| wake | output | 1 | Wake-up from idle |

## Verification
The assertions assume that `ack` and `reti` are single-cycle pulses, that `reti` only arrives while some level is in service, and that the two control-register write strobes are never asserted together. The stimulus raises every control strobe for exactly one clock at a falling edge. It issues `reti` only after a matching accept and never combines byte and bit writes. The assertions on in-service clearing and flag clearing therefore see only sequences the core can legally produce.

// File: rtl/irq_ctl7.sv
module irq_ctl7 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] ext_n,
  input  logic [1:0] std_it,
  input  logic [4:0] std_en,
  input  logic [4:0] std_pri,
  input  logic       gie,
  input  logic       tmr0_evt,
  input  logic       tmr1_evt,
  input  logic       ser_flag,
  input  logic       xw_byte,
  input  logic [7:0] xw_data,
  input  logic       xw_bit,
  input  logic [2:0] xw_idx,
  input  logic       xw_val,
  output logic [7:0] xctl_rd,
  input  logic       ack,
  input  logic       reti,
  output logic       irq_req,
  output logic [7:0] irq_vec,
  output logic       wake
);

  logic [3:0] pin_q, pin_qq, edge_f, edge_n, trig, fall, ext_flag, ext_ack;
  logic [3:0] ie_we, ie_wv;
  logic [1:0] tmr_f;
  logic [7:0] xreg;
  logic       isv_hi, isv_lo;
  logic [6:0] pend, en7, pri7, elig, hi_c, lo_c, cand;
  logic       sel_hi, sel_lo, ack_hit;
  logic [2:0] win, slot;
  logic       bit_wr;

  // sampling and trigger selection
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pin_q  <= 4'hF;
      pin_qq <= 4'hF;
    end else begin
      pin_q  <= ext_n;
      pin_qq <= pin_q;
    end

  assign trig     = {xreg[4], xreg[0], std_it};
  assign fall     = pin_qq & ~pin_q;
  assign ext_flag = (trig & edge_f) | (~trig & ~pin_q);

  // arbitration
  assign pend = {ext_flag[3], ext_flag[2], ser_flag, tmr_f[1], ext_flag[1], tmr_f[0], ext_flag[0]};
  assign en7  = {xreg[6], xreg[2], std_en};
  assign pri7 = {xreg[7], xreg[3], std_pri};
  assign elig = pend & en7 & {7{gie}};
  assign hi_c = elig & pri7;
  assign lo_c = elig & ~pri7;

  assign sel_hi = !isv_hi && (|hi_c);
  assign sel_lo = !isv_hi && !isv_lo && !(|hi_c) && (|lo_c);
  assign cand   = sel_hi ? hi_c : lo_c;

  always_comb begin
    win = 3'd0;
    for (int k = 6; k >= 0; k--)
      if (cand[k]) win = 3'(k);
  end

  assign slot    = (win < 3'd5) ? win : win + 3'd1;
  assign irq_req = sel_hi | sel_lo;
  assign irq_vec = irq_req ? {2'b00, slot, 3'b011} : 8'h00;
  assign wake    = irq_req;
  assign ack_hit = ack & irq_req;

  // flag maintenance
  assign ext_ack = {ack_hit && win == 3'd6, ack_hit && win == 3'd5,
                    ack_hit && win == 3'd2, ack_hit && win == 3'd0};
  assign bit_wr  = xw_bit && !xw_byte;
  assign ie_we   = {xw_byte || (bit_wr && xw_idx == 3'd5),
                    xw_byte || (bit_wr && xw_idx == 3'd1), 2'b00};
  assign ie_wv   = {xw_byte ? xw_data[5] : xw_val,
                    xw_byte ? xw_data[1] : xw_val, 2'b00};

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      edge_n[i] = edge_f[i];
      if (ie_we[i])   edge_n[i] = ie_wv[i];
      if (ext_ack[i]) edge_n[i] = 1'b0;
      if (fall[i])    edge_n[i] = 1'b1;
      if (!trig[i])   edge_n[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      edge_f <= 4'h0;
      tmr_f  <= 2'b00;
    end else begin
      edge_f <= edge_n;
      if (ack_hit && win == 3'd1) tmr_f[0] <= 1'b0;
      if (tmr0_evt)               tmr_f[0] <= 1'b1;
      if (ack_hit && win == 3'd3) tmr_f[1] <= 1'b0;
      if (tmr1_evt)               tmr_f[1] <= 1'b1;
    end

  // control register
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      xreg <= 8'h00;
    else if (xw_byte)
      xreg <= xw_data & 8'hDD;
    else if (bit_wr && xw_idx != 3'd1 && xw_idx != 3'd5)
      xreg[xw_idx] <= xw_val;

  assign xctl_rd = {xreg[7:6], ext_flag[3], xreg[4:2], ext_flag[2], xreg[0]};

  // in-service tracking
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      isv_hi <= 1'b0;
      isv_lo <= 1'b0;
    end else begin
      if (reti) begin
        if (isv_hi) isv_hi <= 1'b0;
        else        isv_lo <= 1'b0;
      end
      if (ack_hit) begin
        if (sel_hi) isv_hi <= 1'b1;
        else        isv_lo <= 1'b1;
      end
    end

  p_vec_shape_r1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec[2:0] == 3'b011 && irq_vec[7:6] == 2'b00 && irq_vec[5:3] != 3'd5));

  p_gie_gates_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !irq_req);

  p_hi_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    isv_hi |-> !irq_req);

  p_reti_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && isv_hi) |=> !isv_hi);

  p_ack_sets_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && !reti) |=> (isv_hi || isv_lo));

  p_edge_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && win == 3'd5 && trig[2] && !fall[2] && !ie_we[2]) |=> !edge_f[2]);

endmodule

// File: tb/sim_irq_ctl7.sv
`timescale 1ns/100ps
module sim_irq_ctl7;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n;
  logic [3:0] ext_n;
  logic [1:0] std_it;
  logic [4:0] std_en, std_pri;
  logic       gie, tmr0_evt, tmr1_evt, ser_flag;
  logic       xw_byte, xw_bit, xw_val;
  logic [7:0] xw_data;
  logic [2:0] xw_idx;
  logic [7:0] xctl_rd, irq_vec;
  logic       ack, reti, irq_req, wake;

  irq_ctl7 u0 (.clk(clk), .rst_n(rst_n), .ext_n(ext_n), .std_it(std_it), .std_en(std_en),
    .std_pri(std_pri), .gie(gie), .tmr0_evt(tmr0_evt), .tmr1_evt(tmr1_evt),
    .ser_flag(ser_flag), .xw_byte(xw_byte), .xw_data(xw_data), .xw_bit(xw_bit),
    .xw_idx(xw_idx), .xw_val(xw_val), .xctl_rd(xctl_rd), .ack(ack), .reti(reti),
    .irq_req(irq_req), .irq_vec(irq_vec), .wake(wake));

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  bit [3:0] m_q = 4'hF, m_qq = 4'hF, m_ef = 0;
  bit [1:0] m_tf = 0;
  bit [7:0] m_x = 0;
  bit       m_hi = 0, m_lo = 0;
  int       vt [7] = '{3, 11, 19, 27, 35, 51, 59};
  int       ext_src [4] = '{0, 2, 5, 6};
  bit       e_req;
  int       e_win, e_lvl;
  bit [7:0] e_rd;
  bit [3:0] e_trig, e_flag;

  task automatic model_eval();
    bit p [7];
    bit en [7];
    bit pr [7];
    e_trig = {m_x[4], m_x[0], std_it};
    for (int e = 0; e < 4; e++) e_flag[e] = e_trig[e] ? m_ef[e] : !m_q[e];
    p[0] = e_flag[0]; p[1] = m_tf[0]; p[2] = e_flag[1]; p[3] = m_tf[1];
    p[4] = ser_flag;  p[5] = e_flag[2]; p[6] = e_flag[3];
    for (int k = 0; k < 5; k++) begin en[k] = std_en[k]; pr[k] = std_pri[k]; end
    en[5] = m_x[2]; pr[5] = m_x[3]; en[6] = m_x[6]; pr[6] = m_x[7];
    e_win = -1; e_lvl = 0;
    if (gie && !m_hi) begin
      for (int k = 0; k < 7; k++)
        if (e_win < 0 && p[k] && en[k] && pr[k]) begin e_win = k; e_lvl = 1; end
      if (e_win < 0 && !m_lo)
        for (int k = 0; k < 7; k++)
          if (e_win < 0 && p[k] && en[k] && !pr[k]) e_win = k;
    end
    e_req = (e_win >= 0);
    e_rd = {m_x[7:6], e_flag[3], m_x[4:2], e_flag[2], m_x[0]};
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_q = 4'hF; m_qq = 4'hF; m_ef = 0; m_tf = 0; m_x = 0; m_hi = 0; m_lo = 0;
    end else begin
      bit ackh;
      bit [3:0] nef;
      model_eval();
      ackh = ack && e_req;
      for (int e = 0; e < 4; e++) begin
        nef[e] = m_ef[e];
        if (e == 2 && xw_byte) nef[e] = xw_data[1];
        if (e == 3 && xw_byte) nef[e] = xw_data[5];
        if (e == 2 && !xw_byte && xw_bit && xw_idx == 1) nef[e] = xw_val;
        if (e == 3 && !xw_byte && xw_bit && xw_idx == 5) nef[e] = xw_val;
        if (ackh && e_win == ext_src[e]) nef[e] = 0;
        if (m_qq[e] && !m_q[e]) nef[e] = 1;
        if (!e_trig[e]) nef[e] = 0;
      end
      m_ef = nef;
      if (ackh && e_win == 1) m_tf[0] = 0;
      if (tmr0_evt) m_tf[0] = 1;
      if (ackh && e_win == 3) m_tf[1] = 0;
      if (tmr1_evt) m_tf[1] = 1;
      if (xw_byte) m_x = xw_data & 8'hDD;
      else if (xw_bit && xw_idx != 1 && xw_idx != 5) m_x[xw_idx] = xw_val;
      if (reti) begin if (m_hi) m_hi = 0; else m_lo = 0; end
      if (ackh) begin if (e_lvl == 1) m_hi = 1; else m_lo = 1; end
      m_qq = m_q; m_q = ext_n;
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    #0.5;
    if (rst_n && !done) begin
      model_eval();
      checks++;
      if (irq_req !== e_req || (e_req && irq_vec !== 8'(vt[e_win]))) begin
        errors++;
        $display("FAIL R2 req/vec act %b/%h exp %b/%h", irq_req, irq_vec, e_req,
                 e_req ? 8'(vt[e_win]) : 8'h00);
      end
      checks++;
      if (xctl_rd !== e_rd) begin
        errors++; $display("FAIL R3 xctl_rd act %h exp %h", xctl_rd, e_rd);
      end
      checks++;
      if (wake !== e_req) begin
        errors++; $display("FAIL R10 wake act %b exp %b", wake, e_req);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++; $display("FAIL %s act %h exp %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ack();
    ack = 1; tick(); ack = 0;
  endtask

  task automatic pulse_reti();
    reti = 1; tick(); reti = 0;
  endtask

  task automatic bitw(input int idx, input bit v);
    xw_bit = 1; xw_idx = 3'(idx); xw_val = v; tick(); xw_bit = 0;
  endtask

  initial begin
    rst_n = 0; ext_n = 4'hF; std_it = 2'b11; std_en = 0; std_pri = 0; gie = 0;
    tmr0_evt = 0; tmr1_evt = 0; ser_flag = 0; xw_byte = 0; xw_data = 0;
    xw_bit = 0; xw_idx = 0; xw_val = 0; ack = 0; reti = 0;
    tick(3);
    #1 chk(irq_req == 0 && xctl_rd == 8'h00, "R3 reset", xctl_rd, 0);
    tick(); rst_n = 1;
    std_en = 5'h1F; tmr0_evt = 1; tick(); tmr0_evt = 0; tick();
    #1 chk(irq_req == 0, "R9 gie off", irq_req, 0);
    tick(); gie = 1;
    #1 chk(irq_req && irq_vec == 8'h0B, "R12 R1 timer0", irq_vec, 8'h0B);
    tick(); tmr1_evt = 1; ser_flag = 1; tick(); tmr1_evt = 0;
    #1 chk(irq_vec == 8'h0B, "R2 order", irq_vec, 8'h0B);
    tick(); pulse_ack();
    #1 chk(irq_req == 0, "R7 same level blocked", irq_req, 0);
    tick(); pulse_reti();
    #1 chk(irq_req && irq_vec == 8'h1B, "R8 R5 after return", irq_vec, 8'h1B);
    tick(); std_pri = 5'b10000;
    #1 chk(irq_vec == 8'h23, "R7 high preferred", irq_vec, 8'h23);
    tick(); pulse_ack();
    #1 chk(irq_req == 0, "R7 high in service blocks", irq_req, 0);
    tick(); ser_flag = 0; std_pri = 0; pulse_reti();
    #1 chk(irq_req && irq_vec == 8'h1B, "R8 high cleared", irq_vec, 8'h1B);
    tick(); pulse_ack(); pulse_reti();
    xw_byte = 1; xw_data = 8'h05; tick(); xw_byte = 0;
    #1 chk(xctl_rd == 8'h05, "R3 byte write", xctl_rd, 8'h05);
    tick(); ext_n[2] = 0; tick(2);
    #1 chk(xctl_rd == 8'h07 && irq_vec == 8'h33, "R4 R1 ext2 edge", xctl_rd, 8'h07);
    tick(); pulse_ack();
    #1 chk(xctl_rd[1] == 0 && irq_req == 0, "R5 flag cleared", xctl_rd, 8'h05);
    tick(); pulse_reti();
    bitw(7, 1); bitw(6, 1);
    ext_n[2] = 1; tick(); ext_n[2] = 0; tick(2);
    pulse_ack();
    ext_n[3] = 0; tick();
    #1 chk(irq_req && irq_vec == 8'h3B, "R7 R6 preempt level", irq_vec, 8'h3B);
    tick(); ext_n[3] = 1; tick();
    #1 chk(xctl_rd[5] == 0 && irq_req == 0 && wake == 0, "R6 not latched", xctl_rd, 8'hC5);
    tick(); ext_n[3] = 0; tick(); pulse_ack();
    #1 chk(irq_req == 0, "R7 nested high", irq_req, 0);
    tick(); pulse_reti();
    #1 chk(irq_vec == 8'h3B, "R8 low still active", irq_vec, 8'h3B);
    tick(); ext_n[3] = 1; ext_n[2] = 1; tick(); pulse_reti();
    #1 chk(irq_req == 0, "R8 both cleared", irq_req, 0);
    tick(); bitw(2, 0);
    #1 chk(xctl_rd == 8'hC1, "R11 bit write", xctl_rd, 8'hC1);
    tick(); bitw(1, 1); bitw(1, 0);
    #1 chk(xctl_rd == 8'hC1, "R11 flag bit write", xctl_rd, 8'hC1);
    tick(); std_it[0] = 0; ext_n[0] = 0; tick();
    #1 chk(irq_vec == 8'h03 && wake == 1, "R10 R1 ext0", irq_vec, 8'h03);
    tick(); std_en[0] = 0;
    #1 chk(irq_req == 0, "R9 source disabled", irq_req, 0);
    tick(3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule